// File: doc/BRIEF.md
# Exception restart PC capture unit

This unit runs beside an in-order instruction stream whose branches and jumps have an architecturally visible delay slot. Each cycle it watches the retire strobe and learns whether the next instruction to retire will be in the delay slot of a branch or jump. The decision comes from the run-time order of retirement, not from the instruction that sits before it in memory. An instruction reached through a branch target is therefore never treated as a delay-slot instruction.

When an exception or interrupt is raised against the presented instruction, the unit stores a restart PC in an EPC register, sets or clears a branch-delay flag (BD), and enters the handler level (EXL). If the faulting instruction is in a delay slot, the stored PC is the PC of the branch or jump, captured when that branch retired, so that restarting runs the branch decision again. The parameter `LEGACY_NT` selects an older variant. In that variant a delay slot behind a not-taken branch stores its own PC with BD clear. An exception-return strobe leaves the handler level, presents EPC as the restart address in that cycle, and clears the delay-slot tracking.

Two small state machines make up the unit. The tracker has three states: `TRK_SEQ` (next instruction is sequential), `TRK_SLOT_TK` (next instruction is in the slot of a taken branch or a jump) and `TRK_SLOT_NT` (next instruction is in the slot of a not-taken branch). A retired branch moves the tracker to `TRK_SLOT_TK` or `TRK_SLOT_NT`. Any other retired instruction moves it to `TRK_SEQ`. An exception or a return also moves it to `TRK_SEQ`, and a cycle with no retire keeps the current state. The level machine has two states, `EL_RUN` and `EL_HANDLER`. It goes from `EL_RUN` to `EL_HANDLER` when an exception is taken, and from `EL_HANDLER` to `EL_RUN` on a return.

Top module: `epc_capture_unit`

## Requirements
- R1: A synchronous active-high reset sets EPC to 0, BD to 0 and EXL to 0, and puts the tracker in `TRK_SEQ`. After reset, the first exception stores its own PC even if a branch retired just before the reset.
- R2: An exception is taken when `retire_i` and `exc_req_i` are both high and EXL is 0. The same holds for interrupts. If the instruction is not in a delay slot, EPC = `pc_i` and BD = 0 on the next cycle, and EXL = 1.
- R3: If the faulting instruction follows a retired taken branch or jump (jumps are driven with `taken_i`=1), EPC = the branch PC and BD = 1 on the next cycle.
- R4: With `LEGACY_NT`=0, a fault in the slot of a not-taken branch also stores the branch PC with BD = 1.
- R5: Delay-slot state exists only if the instruction retired just before was a branch or jump. A fault after any other retired instruction stores its own PC with BD = 0, including at branch PC + 4. The slot closes after one instruction.
- R6: Cycles with `retire_i` low leave the tracker unchanged.
- R7: While EXL = 1, exception requests do not change EPC, BD or EXL.
- R8: `eret_i` with EXL = 1 drives `restart_pc_o` = EPC in that cycle and clears EXL on the next cycle. In every other cycle `restart_pc_o` is 0. `eret_i` with EXL = 0 has no effect.
- R9: A taken return moves the tracker to `TRK_SEQ`. A branch that retired just before the return opens no delay slot after it.
- R10: With `LEGACY_NT`=1, a fault in the slot of a not-taken branch stores the slot instruction's own PC with BD = 0. Taken branches and jumps still store the branch PC with BD = 1.
- R11: A faulting instruction does not retire. A branch that faults stores its own PC with BD = 0 and opens no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire_i | input | 1 | An instruction is presented at retirement this cycle |
| pc_i | input | PC_W | PC of the presented instruction |
| xfer_i | input | 1 | Presented instruction is a branch or jump |
| taken_i | input | 1 | Branch taken (always 1 for jumps) |
| exc_req_i | input | 1 | Exception or interrupt raised against the presented instruction |
| eret_i | input | 1 | Exception-return strobe |
| epc_o | output | PC_W | Stored restart PC |
| bd_o | output | 1 | Branch-delay flag |
| exl_o | output | 1 | Handler-level flag |
| restart_pc_o | output | PC_W | Restart address, valid during a taken return, 0 otherwise |

## Verification
A wrong tracker state does not show until an exception is taken. It then shows one cycle later as a wrong EPC/BD pair: the branch PC with BD set where the own PC was due, or the reverse. For this reason the stimulus ends every tracker scenario with an exception and reads EPC and BD on the next cycle. A wrong handler-level state shows sooner. A stuck EXL makes a later exception fail to update EPC on the next cycle. A missed EXL lets a nested exception overwrite EPC. Both legacy and compliant builds are driven with the same stream, so a mix-up between the two modes shows at the first not-taken slot fault.

// File: rtl/epc_cap_pkg.sv
package epc_cap_pkg;

    // Delay-slot tracker: what the next retiring instruction is.
    typedef enum logic [1:0] {
        TRK_SEQ     = 2'd0,
        TRK_SLOT_TK = 2'd1,
        TRK_SLOT_NT = 2'd2
    } trk_state_e;

    // Exception level.
    typedef enum logic {
        EL_RUN     = 1'b0,
        EL_HANDLER = 1'b1
    } el_state_e;

endpackage

// File: rtl/epc_slot_tracker.sv
module epc_slot_tracker
    import epc_cap_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            retire_i,
    input  logic            xfer_i,
    input  logic            taken_i,
    input  logic            clr_i,
    input  logic [PC_W-1:0] pc_i,
    output logic            in_slot_o,
    output logic            slot_nt_o,
    output logic [PC_W-1:0] br_pc_o
);

    trk_state_e      state_q, state_d;
    logic [PC_W-1:0] br_pc_q;

    // Next state from the dynamic retirement order only.
    always_comb begin
        state_d = state_q;
        if (clr_i) begin
            state_d = TRK_SEQ;
        end else if (retire_i) begin
            unique case (state_q)
                TRK_SEQ, TRK_SLOT_TK, TRK_SLOT_NT: begin
                    if (xfer_i) state_d = taken_i ? TRK_SLOT_TK : TRK_SLOT_NT;
                    else        state_d = TRK_SEQ;
                end
                default: state_d = TRK_SEQ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= TRK_SEQ;
        else     state_q <= state_d;
    end

    // Branch PC is latched at retirement, so no subtraction is needed later.
    always_ff @(posedge clk) begin
        if (rst)                               br_pc_q <= '0;
        else if (retire_i && xfer_i && !clr_i) br_pc_q <= pc_i;
    end

    always_comb begin
        unique case (state_q)
            TRK_SEQ:     begin in_slot_o = 1'b0; slot_nt_o = 1'b0; end
            TRK_SLOT_TK: begin in_slot_o = 1'b1; slot_nt_o = 1'b0; end
            TRK_SLOT_NT: begin in_slot_o = 1'b1; slot_nt_o = 1'b1; end
            default:     begin in_slot_o = 1'b0; slot_nt_o = 1'b0; end
        endcase
        br_pc_o = br_pc_q;
    end

endmodule

// File: rtl/epc_capture_select.sv
module epc_capture_select #(
    parameter int PC_W      = 32,
    parameter bit LEGACY_NT = 1'b0
) (
    input  logic            in_slot_i,
    input  logic            slot_nt_i,
    input  logic [PC_W-1:0] pc_i,
    input  logic [PC_W-1:0] br_pc_i,
    output logic [PC_W-1:0] cap_pc_o,
    output logic            cap_bd_o
);

    logic use_branch;

    generate
        if (LEGACY_NT) begin : g_legacy
            // A not-taken slot may restart at itself: same PC flow.
            assign use_branch = in_slot_i & ~slot_nt_i;
        end else begin : g_compliant
            // Every slot restarts at its branch or jump.
            logic nt_unused;
            assign nt_unused  = slot_nt_i;
            assign use_branch = in_slot_i | (nt_unused & in_slot_i);
        end
    endgenerate

    assign cap_pc_o = use_branch ? br_pc_i : pc_i;
    assign cap_bd_o = use_branch;

endmodule

// File: rtl/epc_exc_ctrl.sv
module epc_exc_ctrl
    import epc_cap_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            retire_i,
    input  logic            exc_req_i,
    input  logic            eret_i,
    input  logic [PC_W-1:0] cap_pc_i,
    input  logic            cap_bd_i,
    output logic [PC_W-1:0] epc_o,
    output logic            bd_o,
    output logic            exl_o,
    output logic [PC_W-1:0] restart_pc_o,
    output logic            leave_o
);

    el_state_e       el_q, el_d;
    logic [PC_W-1:0] epc_q;
    logic            bd_q;
    logic            take;

    assign take    = retire_i && exc_req_i && (el_q == EL_RUN);
    assign leave_o = eret_i && (el_q == EL_HANDLER);

    always_comb begin
        el_d = el_q;
        unique case (el_q)
            EL_RUN:     if (take)    el_d = EL_HANDLER;
            EL_HANDLER: if (leave_o) el_d = EL_RUN;
            default:    el_d = EL_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) el_q <= EL_RUN;
        else     el_q <= el_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            epc_q <= '0;
            bd_q  <= 1'b0;
        end else if (take) begin
            epc_q <= cap_pc_i;
            bd_q  <= cap_bd_i;
        end
    end

    always_comb begin
        epc_o        = epc_q;
        bd_o         = bd_q;
        restart_pc_o = '0;
        unique case (el_q)
            EL_RUN:     exl_o = 1'b0;
            EL_HANDLER: begin
                exl_o = 1'b1;
                if (eret_i) restart_pc_o = epc_q;
            end
            default:    exl_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/epc_capture_unit.sv
module epc_capture_unit #(
    parameter int PC_W      = 32,
    parameter bit LEGACY_NT = 1'b0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            retire_i,
    input  logic [PC_W-1:0] pc_i,
    input  logic            xfer_i,
    input  logic            taken_i,
    input  logic            exc_req_i,
    input  logic            eret_i,
    output logic [PC_W-1:0] epc_o,
    output logic            bd_o,
    output logic            exl_o,
    output logic [PC_W-1:0] restart_pc_o
);

    logic            trk_in_slot;
    logic            trk_slot_nt;
    logic [PC_W-1:0] trk_br_pc;
    logic [PC_W-1:0] cap_pc;
    logic            cap_bd;
    logic            leave;
    logic            trk_clr;

    // A faulting instruction does not retire; a return restarts the stream.
    assign trk_clr = (retire_i && exc_req_i) || leave;

    epc_slot_tracker #(.PC_W(PC_W)) trk_i (
        .clk       (clk),
        .rst       (rst),
        .retire_i  (retire_i),
        .xfer_i    (xfer_i),
        .taken_i   (taken_i),
        .clr_i     (trk_clr),
        .pc_i      (pc_i),
        .in_slot_o (trk_in_slot),
        .slot_nt_o (trk_slot_nt),
        .br_pc_o   (trk_br_pc)
    );

    epc_capture_select #(.PC_W(PC_W), .LEGACY_NT(LEGACY_NT)) sel_i (
        .in_slot_i (trk_in_slot),
        .slot_nt_i (trk_slot_nt),
        .pc_i      (pc_i),
        .br_pc_i   (trk_br_pc),
        .cap_pc_o  (cap_pc),
        .cap_bd_o  (cap_bd)
    );

    epc_exc_ctrl #(.PC_W(PC_W)) ctl_i (
        .clk          (clk),
        .rst          (rst),
        .retire_i     (retire_i),
        .exc_req_i    (exc_req_i),
        .eret_i       (eret_i),
        .cap_pc_i     (cap_pc),
        .cap_bd_i     (cap_bd),
        .epc_o        (epc_o),
        .bd_o         (bd_o),
        .exl_o        (exl_o),
        .restart_pc_o (restart_pc_o),
        .leave_o      (leave)
    );

endmodule

// File: rtl/epc_capture_chk.sv
module epc_capture_chk #(
    parameter int PC_W      = 32,
    parameter bit LEGACY_NT = 1'b0
) (
    input logic            clk,
    input logic            rst,
    input logic            retire_i,
    input logic [PC_W-1:0] pc_i,
    input logic            exc_req_i,
    input logic            eret_i,
    input logic [PC_W-1:0] epc_o,
    input logic            bd_o,
    input logic            exl_o,
    input logic [PC_W-1:0] restart_pc_o,
    input logic            in_slot,
    input logic [PC_W-1:0] br_pc
);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!exl_o && !bd_o && epc_o == '0));

    p_take_sets_exl_r2: assert property (@(posedge clk) disable iff (rst)
        (!exl_o && retire_i && exc_req_i) |=> exl_o);

    p_own_pc_r2: assert property (@(posedge clk) disable iff (rst)
        (!exl_o && retire_i && exc_req_i && !in_slot) |=> (epc_o == $past(pc_i) && !bd_o));

    p_slot_branch_pc_r3: assert property (@(posedge clk) disable iff (rst)
        (!LEGACY_NT && !exl_o && retire_i && exc_req_i && in_slot) |=> (bd_o && epc_o == $past(br_pc)));

    p_bd_needs_slot_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(bd_o) |-> $past(in_slot));

    p_handler_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (exl_o && !eret_i) |=> (exl_o && $stable(epc_o) && $stable(bd_o)));

    p_eret_leaves_r8: assert property (@(posedge clk) disable iff (rst)
        (exl_o && eret_i) |=> !exl_o);

    p_restart_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !(exl_o && eret_i) |-> (restart_pc_o == '0));

    p_restart_epc_r8: assert property (@(posedge clk) disable iff (rst)
        (exl_o && eret_i) |-> (restart_pc_o == epc_o));

endmodule

bind epc_capture_unit epc_capture_chk #(.PC_W(PC_W), .LEGACY_NT(LEGACY_NT)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .retire_i     (retire_i),
    .pc_i         (pc_i),
    .exc_req_i    (exc_req_i),
    .eret_i       (eret_i),
    .epc_o        (epc_o),
    .bd_o         (bd_o),
    .exl_o        (exl_o),
    .restart_pc_o (restart_pc_o),
    .in_slot      (trk_in_slot),
    .br_pc        (trk_br_pc)
);

// File: tb/epc_capture_unit_tb_top.sv
`timescale 1ns/1ps
module epc_capture_unit_tb_top;

    localparam int PC_W = 32;

    logic            clk = 1'b0;
    logic            rst;
    logic            retire, xfer, taken, exc, eret;
    logic [PC_W-1:0] pc;
    logic [PC_W-1:0] epc_c, rpc_c, epc_l, rpc_l;
    logic            bd_c, exl_c, bd_l, exl_l;

    int  checks   = 0;
    int  failures = 0;
    bit  done     = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    epc_capture_unit #(.PC_W(PC_W), .LEGACY_NT(1'b0)) dut_i (
        .clk(clk), .rst(rst), .retire_i(retire), .pc_i(pc), .xfer_i(xfer),
        .taken_i(taken), .exc_req_i(exc), .eret_i(eret),
        .epc_o(epc_c), .bd_o(bd_c), .exl_o(exl_c), .restart_pc_o(rpc_c)
    );

    epc_capture_unit #(.PC_W(PC_W), .LEGACY_NT(1'b1)) dut_leg_i (
        .clk(clk), .rst(rst), .retire_i(retire), .pc_i(pc), .xfer_i(xfer),
        .taken_i(taken), .exc_req_i(exc), .eret_i(eret),
        .epc_o(epc_l), .bd_o(bd_l), .exl_o(exl_l), .restart_pc_o(rpc_l)
    );

    typedef struct packed {
        logic        ret;
        logic        xf;
        logic        tk;
        logic        ex;
        logic        er;
        logic [31:0] pc;
        logic [31:0] e_epc;
        logic        e_bd;
        logic        e_exl;
        logic [31:0] l_epc;
        logic        l_bd;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 32;
    // ret xf tk ex er  pc  | compliant epc bd exl | legacy epc bd | req
    localparam vec_t VEC [NV] = '{
        '{1'b1,1'b0,1'b0,1'b0,1'b0,32'h100, 32'h000,1'b0,1'b0, 32'h000,1'b0, 4'd2},
        '{1'b1,1'b0,1'b0,1'b1,1'b0,32'h104, 32'h104,1'b0,1'b1, 32'h104,1'b0, 4'd2},  // R2
        '{1'b0,1'b0,1'b0,1'b0,1'b1,32'h000, 32'h104,1'b0,1'b0, 32'h104,1'b0, 4'd8},
        '{1'b1,1'b1,1'b1,1'b0,1'b0,32'h200, 32'h104,1'b0,1'b0, 32'h104,1'b0, 4'd3},
        '{1'b1,1'b0,1'b0,1'b1,1'b0,32'h204, 32'h200,1'b1,1'b1, 32'h200,1'b1, 4'd3},  // R3, R10 taken
        '{1'b0,1'b0,1'b0,1'b0,1'b1,32'h000, 32'h200,1'b1,1'b0, 32'h200,1'b1, 4'd8},
        '{1'b1,1'b1,1'b0,1'b0,1'b0,32'h400, 32'h200,1'b1,1'b0, 32'h200,1'b1, 4'd4},
        '{1'b1,1'b0,1'b0,1'b1,1'b0,32'h404, 32'h400,1'b1,1'b1, 32'h404,1'b0, 4'd4},  // R4, R10
        '{1'b0,1'b0,1'b0,1'b0,1'b1,32'h000, 32'h400,1'b1,1'b0, 32'h404,1'b0, 4'd8},
        '{1'b1,1'b1,1'b1,1'b0,1'b0,32'h500, 32'h400,1'b1,1'b0, 32'h404,1'b0, 4'd5},  // jump
        '{1'b1,1'b0,1'b0,1'b0,1'b0,32'h504, 32'h400,1'b1,1'b0, 32'h404,1'b0, 4'd5},
        '{1'b1,1'b0,1'b0,1'b1,1'b0,32'h508, 32'h508,1'b0,1'b1, 32'h508,1'b0, 4'd5},  // R5 slot closed
        '{1'b0,1'b0,1'b0,1'b0,1'b1,32'h000, 32'h508,1'b0,1'b0, 32'h508,1'b0, 4'd8},
        '{1'b1,1'b0,1'b0,1'b0,1'b0,32'h900, 32'h508,1'b0,1'b0, 32'h508,1'b0, 4'd5},
        '{1'b1,1'b0,1'b0,1'b1,1'b0,32'h704, 32'h704,1'b0,1'b1, 32'h704,1'b0, 4'd5},  // R5 target at br+4
        '{1'b0,1'b0,1'b0,1'b0,1'b1,32'h000, 32'h704,1'b0,1'b0, 32'h704,1'b0, 4'd8},
        '{1'b1,1'b1,1'b1,1'b0,1'b0,32'hA00, 32'h704,1'b0,1'b0, 32'h704,1'b0, 4'd6},
        '{1'b0,1'b0,1'b0,1'b0,1'b0,32'h000, 32'h704,1'b0,1'b0, 32'h704,1'b0, 4'd6},
        '{1'b0,1'b0,1'b0,1'b0,1'b0,32'h000, 32'h704,1'b0,1'b0, 32'h704,1'b0, 4'd6},
        '{1'b1,1'b0,1'b0,1'b1,1'b0,32'hA04, 32'hA00,1'b1,1'b1, 32'hA00,1'b1, 4'd6},  // R6 idle gap
        '{1'b0,1'b0,1'b0,1'b0,1'b1,32'h000, 32'hA00,1'b1,1'b0, 32'hA00,1'b1, 4'd8},
        '{1'b1,1'b0,1'b0,1'b1,1'b0,32'hB00, 32'hB00,1'b0,1'b1, 32'hB00,1'b0, 4'd2},
        '{1'b1,1'b1,1'b1,1'b0,1'b0,32'hC00, 32'hB00,1'b0,1'b1, 32'hB00,1'b0, 4'd7},
        '{1'b1,1'b0,1'b0,1'b1,1'b0,32'hC04, 32'hB00,1'b0,1'b1, 32'hB00,1'b0, 4'd7},  // R7 nested ignored
        '{1'b1,1'b1,1'b1,1'b0,1'b0,32'hC08, 32'hB00,1'b0,1'b1, 32'hB00,1'b0, 4'd9},
        '{1'b0,1'b0,1'b0,1'b0,1'b1,32'h000, 32'hB00,1'b0,1'b0, 32'hB00,1'b0, 4'd8},
        '{1'b1,1'b0,1'b0,1'b1,1'b0,32'hC0C, 32'hC0C,1'b0,1'b1, 32'hC0C,1'b0, 4'd9},  // R9
        '{1'b0,1'b0,1'b0,1'b0,1'b1,32'h000, 32'hC0C,1'b0,1'b0, 32'hC0C,1'b0, 4'd8},
        '{1'b1,1'b1,1'b1,1'b1,1'b0,32'hE00, 32'hE00,1'b0,1'b1, 32'hE00,1'b0, 4'd11}, // R11
        '{1'b0,1'b0,1'b0,1'b0,1'b1,32'h000, 32'hE00,1'b0,1'b0, 32'hE00,1'b0, 4'd8},
        '{1'b1,1'b0,1'b0,1'b1,1'b0,32'hE04, 32'hE04,1'b0,1'b1, 32'hE04,1'b0, 4'd11},
        '{1'b0,1'b0,1'b0,1'b0,1'b1,32'h000, 32'hE04,1'b0,1'b0, 32'hE04,1'b0, 4'd8}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic r, input logic x, input logic t,
                         input logic e, input logic q, input logic [31:0] p);
        retire = r; xfer = x; taken = t; exc = e; eret = q; pc = p;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
        do_reset();

        // R1: reset state at the ports
        check("R1 epc",     epc_c, 32'h0);
        check("R1 bd",      {31'd0, bd_c}, 32'h0);
        check("R1 exl",     {31'd0, exl_c}, 32'h0);
        check("R1 restart", rpc_c, 32'h0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].ret, VEC[i].xf, VEC[i].tk, VEC[i].ex, VEC[i].er, VEC[i].pc);
            @(negedge clk);
            check($sformatf("R%0d row%0d epc", VEC[i].req, i), epc_c, VEC[i].e_epc);
            check($sformatf("R%0d row%0d bd", VEC[i].req, i), {31'd0, bd_c}, {31'd0, VEC[i].e_bd});
            check($sformatf("R%0d row%0d exl", VEC[i].req, i), {31'd0, exl_c}, {31'd0, VEC[i].e_exl});
            check($sformatf("R10 legacy R%0d row%0d epc", VEC[i].req, i), epc_l, VEC[i].l_epc);
            check($sformatf("R10 legacy R%0d row%0d bd", VEC[i].req, i), {31'd0, bd_l}, {31'd0, VEC[i].l_bd});
            check($sformatf("R10 legacy R%0d row%0d exl", VEC[i].req, i), {31'd0, exl_l}, {31'd0, VEC[i].e_exl});
        end

        // R8: restart address only during a taken return
        drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 32'h1234);
        @(negedge clk);
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
        #1 check("R8 restart idle in handler", rpc_c, 32'h0);
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, '0);
        #1 check("R8 restart during eret", rpc_c, 32'h1234);
        @(negedge clk);
        check("R8 exl cleared", {31'd0, exl_c}, 32'h0);
        #1 check("R8 eret at level run restart", rpc_c, 32'h0);
        @(negedge clk);
        check("R8 eret at level run exl", {31'd0, exl_c}, 32'h0);
        check("R8 eret at level run epc", epc_c, 32'h1234);

        // R1: reset clears handler level and tracker
        drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 32'hF80);
        @(negedge clk);
        drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 32'hF00);
        @(negedge clk);
        rst = 1'b1;
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
        @(negedge clk);
        rst = 1'b0;
        check("R1 exl after mid reset", {31'd0, exl_c}, 32'h0);
        check("R1 epc after mid reset", epc_c, 32'h0);
        drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 32'hF04);
        @(negedge clk);
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
        check("R1 tracker cleared epc", epc_c, 32'hF04);
        check("R1 tracker cleared bd", {31'd0, bd_c}, 32'h0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule